// File: doc/BRIEF.md
# Serial Display Command and Data Decoder

This block sits behind the byte receiver of a four-wire serial display link and turns each received byte into either a frame-buffer write or a controller command. A byte strobe delivers one byte per cycle together with the sampled chip-select (active low) and data/command lines. Data bytes are stored at a page/column cursor that steps forward after every write. Command bytes change the display state flags, move the cursor or load an 8-bit contrast value. The contrast value needs two bytes: an opcode followed by an argument.

The block owns the write port of a frame buffer of 8 pages by 128 columns of 8-bit columns, which gives 1024 entries at address page*128+column. It shows the flag and contrast registers as outputs. A dirty indication tells a display refresh engine that something visible has changed, and that engine clears it with an acknowledge.

A system reset, or a falling edge on the display's own active-low reset pin, puts all state back to its defaults. It then starts a sweep that writes zero into every buffer location while a busy output is high. Scrolling and addressing modes other than page addressing are not handled.

Top module: `disp_cmd_data_decoder`

## Requirements
- R1: A byte is dropped when cs_n is 1. A dropped byte makes no buffer write and changes no cursor, flag or contrast state.
- R2: When a byte is taken with dc=1, fb_we is high in the following cycle, with fb_addr = page*128+column and fb_wdata = the byte. A command byte (dc=0) never produces a write.
- R3: After each data write the column goes up by one. Column 127 wraps to 0 and moves the page up by one. Page 7 wraps to page 0.
- R4: Command 0xA6 clears invert and 0xA7 sets it. Command 0xAE clears disp_on and 0xAF sets it.
- R5: Commands 0xB0 to 0xB7 load the cursor page with the opcode minus 0xB0.
- R6: Commands 0x00 to 0x0F load column bits 3:0 from opcode bits 3:0. Commands 0x10 to 0x1F load column bits 6:4 from opcode bits 2:0, and opcode bit 3 is dropped. The other column bits are kept in both cases.
- R7: Commands 0xA0 and 0xA1 set seg_remap to 0 and 1. Commands 0xC0 and 0xC8 set com_flip to 0 and 1.
- R8: Command 0x81 arms a pending state. The next byte taken with dc=0 is loaded into contrast whatever its value, is not decoded as a command, and clears the pending state. Data bytes in between are written normally and leave the pending state armed.
- R9: Any other command byte has no effect on cursor, flags or contrast.
- R10: System reset, or a falling edge of disp_rst_n, sets the cursor to page 0 column 0. It clears disp_on, invert, seg_remap, com_flip, dirty and the pending state, and sets contrast to 0x7F.
- R11: After a reset, busy is high while fb_we writes 0 to addresses 0 to 1023 in ascending order, one per cycle, in the 1024 cycles that follow. Bytes offered while busy is high are dropped.
- R12: dirty goes to 1 in the cycle after a data write, a flag command (0xA0, 0xA1, 0xA6, 0xA7, 0xAE, 0xAF, 0xC0, 0xC8) or a contrast load. Cursor commands do not set it. dirty_ack clears it, but a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| disp_rst_n | input | 1 | Display reset pin; its falling edge reinitialises the block |
| cs_n | input | 1 | Chip select, active low |
| dc | input | 1 | 1 = data byte, 0 = command byte |
| byte_valid | input | 1 | Strobe marking a received byte |
| byte_in | input | 8 | Received byte |
| dirty_ack | input | 1 | Clears dirty |
| fb_we | output | 1 | Frame-buffer write enable |
| fb_addr | output | 10 | Frame-buffer address, page*128+column |
| fb_wdata | output | 8 | Frame-buffer write data |
| busy | output | 1 | Clear sweep in progress |
| disp_on | output | 1 | Display on flag |
| invert | output | 1 | Inverted display flag |
| seg_remap | output | 1 | Segment (column) mapping reversed |
| com_flip | output | 1 | COM scan direction reversed |
| contrast | output | 8 | Contrast value |
| dirty | output | 1 | Visible state changed since last acknowledge |

## Verification
Every one of the 256 opcode values is applied in turn against a running model of cursor, flags and contrast. Each opcode is followed by a probe data byte, and the probe's write address shows whether the cursor moved exactly as predicted. This separates the ranged cursor opcodes, the single flag opcodes, the two-byte contrast sequence and the opcodes that must be ignored. Cursor positions at the last column and the last page show the two wrap paths, and bytes with chip select high show that dropped traffic cannot move the cursor. A mid-run pin reset with a command held on the input, plus the full 1024-address sweep, shows the reset values and that traffic is dropped while busy is high.

// File: rtl/disp_dec_pkg.sv
package disp_dec_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OP_COL_LO_BASE = 8'h00;
  localparam logic [7:0] OP_COL_HI_BASE = 8'h10;
  localparam logic [7:0] OP_CONTRAST    = 8'h81;
  localparam logic [7:0] OP_SEG_FWD     = 8'hA0;
  localparam logic [7:0] OP_SEG_REV     = 8'hA1;
  localparam logic [7:0] OP_SHOW_NORMAL = 8'hA6;
  localparam logic [7:0] OP_SHOW_INVERT = 8'hA7;
  localparam logic [7:0] OP_PANEL_OFF   = 8'hAE;
  localparam logic [7:0] OP_PANEL_ON    = 8'hAF;
  localparam logic [7:0] OP_PAGE_BASE   = 8'hB0;
  localparam logic [7:0] OP_COM_FWD     = 8'hC0;
  localparam logic [7:0] OP_COM_REV     = 8'hC8;

  // One-hot-ish action set produced by the decoder for a command byte
  typedef struct packed {
    logic inv_clr;
    logic inv_set;
    logic on_clr;
    logic on_set;
    logic seg_fwd;
    logic seg_rev;
    logic com_fwd;
    logic com_rev;
    logic page_ld;
    logic col_lo;
    logic col_hi;
    logic arm;
    logic arg_ld;
  } cmd_act_t;
endpackage

// File: rtl/disp_cmd_decode.sv
module disp_cmd_decode
  import disp_dec_pkg::*;
#(
  parameter int PAGES = 8
) (
  input  logic [BYTE_W-1:0] op,
  input  logic              pending,
  output cmd_act_t          act
);
  localparam logic [7:0] PAGE_LAST = 8'(OP_PAGE_BASE + 8'(PAGES - 1));

  always_comb begin
    act = '0;
    if (pending) begin
      act.arg_ld = 1'b1;
    end else if (op[7:4] == OP_COL_LO_BASE[7:4]) begin
      act.col_lo = 1'b1;
    end else if (op[7:4] == OP_COL_HI_BASE[7:4]) begin
      act.col_hi = 1'b1;
    end else if (op >= OP_PAGE_BASE && op <= PAGE_LAST) begin
      act.page_ld = 1'b1;
    end else begin
      case (op)
        OP_SHOW_NORMAL: act.inv_clr = 1'b1;
        OP_SHOW_INVERT: act.inv_set = 1'b1;
        OP_PANEL_OFF:   act.on_clr  = 1'b1;
        OP_PANEL_ON:    act.on_set  = 1'b1;
        OP_SEG_FWD:     act.seg_fwd = 1'b1;
        OP_SEG_REV:     act.seg_rev = 1'b1;
        OP_COM_FWD:     act.com_fwd = 1'b1;
        OP_COM_REV:     act.com_rev = 1'b1;
        OP_CONTRAST:    act.arm     = 1'b1;
        default:        act = '0;
      endcase
    end
  end
endmodule

// File: rtl/disp_cursor.sv
module disp_cursor #(
  parameter int COLS  = 128,
  parameter int PAGES = 8,
  localparam int COL_W = $clog2(COLS),
  localparam int PG_W  = $clog2(PAGES)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             adv,
  input  logic             page_ld,
  input  logic [PG_W-1:0]  page_val,
  input  logic             col_lo,
  input  logic             col_hi,
  input  logic [3:0]       nib,
  output logic [PG_W-1:0]  page,
  output logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] COL_LAST  = COL_W'(COLS - 1);
  localparam logic [PG_W-1:0]  PAGE_LAST = PG_W'(PAGES - 1);
  localparam logic [COL_W-1:0] LO_MASK   = COL_W'(15);

  always_ff @(posedge clk) begin
    if (clr) begin
      page <= '0;
      col  <= '0;
    end else if (adv) begin
      if (col == COL_LAST) begin
        col  <= '0;
        page <= (page == PAGE_LAST) ? '0 : page + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end else if (page_ld) begin
      page <= page_val;
    end else if (col_lo) begin
      col <= (col & ~LO_MASK) | COL_W'(nib);
    end else if (col_hi) begin
      col <= (col & LO_MASK) | COL_W'({nib, 4'b0000});
    end
  end

  // R3
  col_wrap_chk: assert property (@(posedge clk) disable iff (clr)
    (adv && col == COL_LAST) |=> (col == '0));

  // R3
  page_wrap_chk: assert property (@(posedge clk) disable iff (clr)
    (adv && col == COL_LAST && page == PAGE_LAST) |=> (page == '0));
endmodule

// File: rtl/disp_clear_sweep.sv
module disp_clear_sweep #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          clr,
  output logic          busy,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (clr) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (busy) begin
      if (addr == LAST) begin
        busy <= 1'b0;
      end else begin
        addr <= addr + 1'b1;
      end
    end
  end

  // R11
  sweep_full_chk: assert property (@(posedge clk) disable iff (clr)
    $fell(busy) |-> ($past(addr) == LAST));

  // R11
  sweep_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (busy && addr != LAST) |=> busy);
endmodule

// File: rtl/disp_cmd_data_decoder.sv
module disp_cmd_data_decoder
  import disp_dec_pkg::*;
#(
  parameter int COLS = 128,
  parameter int PAGES = 8,
  parameter logic [7:0] CONTRAST_INIT = 8'h7F
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            disp_rst_n,
  input  logic                            cs_n,
  input  logic                            dc,
  input  logic                            byte_valid,
  input  logic [7:0]                      byte_in,
  input  logic                            dirty_ack,
  output logic                            fb_we,
  output logic [$clog2(COLS*PAGES)-1:0]   fb_addr,
  output logic [7:0]                      fb_wdata,
  output logic                            busy,
  output logic                            disp_on,
  output logic                            invert,
  output logic                            seg_remap,
  output logic                            com_flip,
  output logic [7:0]                      contrast,
  output logic                            dirty
);
  localparam int DEPTH = COLS * PAGES;
  localparam int AW    = $clog2(DEPTH);
  localparam int COL_W = $clog2(COLS);
  localparam int PG_W  = $clog2(PAGES);

  // Display reset pin edge detect
  logic pin_q;
  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= disp_rst_n;
  end
  logic init;
  assign init = rst | (pin_q & ~disp_rst_n);

  // Byte acceptance
  logic acc, data_wr, cmd_acc;
  assign acc     = byte_valid & ~cs_n & ~busy;
  assign data_wr = acc & dc;
  assign cmd_acc = acc & ~dc;

  logic     pending;
  cmd_act_t act;

  disp_cmd_decode #(.PAGES(PAGES)) u_dec (
    .op      (byte_in),
    .pending (pending),
    .act     (act)
  );

  logic [PG_W-1:0]  cur_page;
  logic [COL_W-1:0] cur_col;

  disp_cursor #(.COLS(COLS), .PAGES(PAGES)) u_cur (
    .clk      (clk),
    .clr      (init),
    .adv      (data_wr),
    .page_ld  (cmd_acc & act.page_ld),
    .page_val (PG_W'(byte_in - OP_PAGE_BASE)),
    .col_lo   (cmd_acc & act.col_lo),
    .col_hi   (cmd_acc & act.col_hi),
    .nib      (byte_in[3:0]),
    .page     (cur_page),
    .col      (cur_col)
  );

  logic [AW-1:0] sw_addr;

  disp_clear_sweep #(.DEPTH(DEPTH)) u_sweep (
    .clk  (clk),
    .clr  (init),
    .busy (busy),
    .addr (sw_addr)
  );

  // Flags, contrast and pending command
  always_ff @(posedge clk) begin
    if (init) begin
      disp_on   <= 1'b0;
      invert    <= 1'b0;
      seg_remap <= 1'b0;
      com_flip  <= 1'b0;
      contrast  <= CONTRAST_INIT;
      pending   <= 1'b0;
    end else if (cmd_acc) begin
      if (act.inv_clr) invert    <= 1'b0;
      if (act.inv_set) invert    <= 1'b1;
      if (act.on_clr)  disp_on   <= 1'b0;
      if (act.on_set)  disp_on   <= 1'b1;
      if (act.seg_fwd) seg_remap <= 1'b0;
      if (act.seg_rev) seg_remap <= 1'b1;
      if (act.com_fwd) com_flip  <= 1'b0;
      if (act.com_rev) com_flip  <= 1'b1;
      if (act.arm)     pending   <= 1'b1;
      if (act.arg_ld) begin
        contrast <= byte_in;
        pending  <= 1'b0;
      end
    end
  end

  // Frame-buffer write port, registered
  logic [AW-1:0] cur_addr;
  assign cur_addr = AW'(cur_page) * AW'(COLS) + AW'(cur_col);

  always_ff @(posedge clk) begin
    if (init) begin
      fb_we    <= 1'b0;
      fb_addr  <= '0;
      fb_wdata <= '0;
    end else if (busy) begin
      fb_we    <= 1'b1;
      fb_addr  <= sw_addr;
      fb_wdata <= '0;
    end else begin
      fb_we    <= data_wr;
      fb_addr  <= cur_addr;
      fb_wdata <= byte_in;
    end
  end

  // Dirty tracking
  logic vis_cmd;
  assign vis_cmd = cmd_acc & (act.inv_clr | act.inv_set | act.on_clr | act.on_set |
                              act.seg_fwd | act.seg_rev | act.com_fwd | act.com_rev |
                              act.arg_ld);

  always_ff @(posedge clk) begin
    if (init)                    dirty <= 1'b0;
    else if (data_wr | vis_cmd)  dirty <= 1'b1;
    else if (dirty_ack)          dirty <= 1'b0;
  end

  // R1
  cs_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && cs_n && !busy && !init) |=> !fb_we);

  // R11
  sweep_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !init) |=> (fb_we && fb_wdata == '0));

  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && cmd_acc && !init) |=> !pending);

  // R12
  dirty_set_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !init) |=> dirty);
endmodule

// File: tb/tb_disp_cmd_data_decoder.sv
module tb_disp_cmd_data_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       disp_rst_n = 1'b1;
  logic       cs_n = 1'b1;
  logic       dc = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = '0;
  logic       dirty_ack = 1'b0;
  logic       fb_we, busy, disp_on, invert, seg_remap, com_flip, dirty;
  logic [9:0] fb_addr;
  logic [7:0] fb_wdata, contrast;

  always #4 clk = ~clk;

  disp_cmd_data_decoder dut (
    .clk(clk), .rst(rst), .disp_rst_n(disp_rst_n), .cs_n(cs_n), .dc(dc),
    .byte_valid(byte_valid), .byte_in(byte_in), .dirty_ack(dirty_ack),
    .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata), .busy(busy),
    .disp_on(disp_on), .invert(invert), .seg_remap(seg_remap),
    .com_flip(com_flip), .contrast(contrast), .dirty(dirty)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // Bench model
  int m_page, m_col, m_con;
  bit m_inv, m_on, m_seg, m_com, m_pend;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_page = 0; m_col = 0; m_con = 8'h7F;
    m_inv = 0; m_on = 0; m_seg = 0; m_com = 0; m_pend = 0;
  endtask

  // returns 1 when the command is expected to set dirty
  function automatic bit model_cmd(input int b);
    if (m_pend) begin
      m_con = b; m_pend = 0; return 1'b1;
    end
    if (b < 16)                  begin m_col = (m_col & 8'h70) | (b & 15); return 1'b0; end
    if (b < 32)                  begin m_col = (m_col & 8'h0F) | ((b & 7) << 4); return 1'b0; end
    if (b >= 8'hB0 && b <= 8'hB7) begin m_page = b - 8'hB0; return 1'b0; end
    case (b)
      8'hA6: begin m_inv = 0; return 1'b1; end
      8'hA7: begin m_inv = 1; return 1'b1; end
      8'hAE: begin m_on = 0;  return 1'b1; end
      8'hAF: begin m_on = 1;  return 1'b1; end
      8'hA0: begin m_seg = 0; return 1'b1; end
      8'hA1: begin m_seg = 1; return 1'b1; end
      8'hC0: begin m_com = 0; return 1'b1; end
      8'hC8: begin m_com = 1; return 1'b1; end
      8'h81: begin m_pend = 1; return 1'b0; end
      default: return 1'b0;
    endcase
  endfunction

  task automatic send(input logic d, input logic [7:0] b, input logic cs, input logic ack);
    byte_valid = 1'b1; dc = d; byte_in = b; cs_n = cs; dirty_ack = ack;
    @(negedge clk);
    byte_valid = 1'b0; dirty_ack = 1'b0; cs_n = 1'b1;
  endtask

  task automatic idle_ack();
    dirty_ack = 1'b1;
    @(negedge clk);
    dirty_ack = 1'b0;
  endtask

  task automatic check_state(input string req);
    chk({req, " invert"},    invert,    m_inv);
    chk({req, " disp_on"},   disp_on,   m_on);
    chk({req, " seg_remap"}, seg_remap, m_seg);
    chk({req, " com_flip"},  com_flip,  m_com);
    chk({req, " contrast"},  contrast,  m_con);
  endtask

  // data write probe: checks write address against model, then advances model
  task automatic probe(input string req, input logic [7:0] b);
    send(1'b1, b, 1'b0, 1'b0);
    chk({req, " data fb_we"},    fb_we,    1);
    chk({req, " data fb_addr"},  fb_addr,  m_page * 128 + m_col);
    chk({req, " data fb_wdata"}, fb_wdata, b);
    m_col++;
    if (m_col == 128) begin
      m_col = 0;
      m_page = (m_page + 1) % 8;
    end
  endtask

  // Called at the negedge right after the first sweep write edge
  task automatic check_sweep();
    for (int i = 0; i < 1024; i++) begin
      if (i > 0) @(negedge clk);
      chk("R11 sweep fb_we",    fb_we,    1);
      chk("R11 sweep fb_addr",  fb_addr,  i);
      chk("R11 sweep fb_wdata", fb_wdata, 0);
      if (i < 1023) chk("R11 sweep busy", busy, 1);
      if (i == 1000) byte_valid = 1'b0;
    end
    @(negedge clk);
    chk("R11 sweep end busy",  busy,  0);
    chk("R11 sweep end fb_we", fb_we, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset busy", busy, 1);
    chk("R10 reset fb_we", fb_we, 0);
    chk("R10 reset dirty", dirty, 0);
    check_state("R10 reset");
    rst = 1'b0;
    @(negedge clk);
    check_sweep();

    // Cursor at origin after reset: R10
    probe("R10 origin", 8'h3C);

    // Opcode sweep R4 R5 R6 R7 R8 R9 R12 R2
    for (int op = 0; op < 256; op++) begin
      bit exp_d;
      string tag;
      idle_ack();
      chk("R12 ack clears dirty", dirty, 0);
      tag = $sformatf("R4-7/R9 op %0h", op);
      exp_d = model_cmd(op);
      send(1'b0, 8'(op), 1'b0, 1'b0);
      chk({tag, " R2 no write on command"}, fb_we, 0);
      chk({tag, " R12 dirty"}, dirty, exp_d);
      check_state(tag);
      probe(tag, 8'(op ^ 8'h5A));
    end

    // R3 page and column wrap
    void'(model_cmd(8'hB7)); send(1'b0, 8'hB7, 1'b0, 1'b0);
    void'(model_cmd(8'h0F)); send(1'b0, 8'h0F, 1'b0, 1'b0);
    void'(model_cmd(8'h17)); send(1'b0, 8'h17, 1'b0, 1'b0);
    chk("R3 last cell model", m_page * 128 + m_col, 1023);
    probe("R3 last cell", 8'hC3);
    probe("R3 wrap to origin", 8'h3C);
    chk("R3 wrapped model", m_page * 128 + m_col, 1);
    void'(model_cmd(8'hB2)); send(1'b0, 8'hB2, 1'b0, 1'b0);
    void'(model_cmd(8'h0F)); send(1'b0, 8'h0F, 1'b0, 1'b0);
    void'(model_cmd(8'h17)); send(1'b0, 8'h17, 1'b0, 1'b0);
    probe("R3 column end page 2", 8'h11);
    probe("R3 next page", 8'h22);

    // R1 chip select high drops bytes
    void'(model_cmd(8'hB1)); send(1'b0, 8'hB1, 1'b0, 1'b0);
    void'(model_cmd(8'h00)); send(1'b0, 8'h00, 1'b0, 1'b0);
    void'(model_cmd(8'h10)); send(1'b0, 8'h10, 1'b0, 1'b0);
    send(1'b1, 8'hEE, 1'b1, 1'b0);
    chk("R1 data with cs_n high fb_we", fb_we, 0);
    send(1'b0, m_inv ? 8'hA6 : 8'hA7, 1'b1, 1'b0);
    send(1'b0, 8'hB5, 1'b1, 1'b0);
    check_state("R1 command with cs_n high");
    probe("R1 cursor unchanged", 8'h44);
    chk("R1 address model", m_page * 128 + m_col, 129);

    // R8 contrast sequence with data in between
    void'(model_cmd(8'h81)); send(1'b0, 8'h81, 1'b0, 1'b0);
    probe("R8 data while pending", 8'h55);
    chk("R8 contrast unchanged while pending", contrast, m_con);
    void'(model_cmd(m_on ? 8'hAE : 8'hAF));
    send(1'b0, m_on ? 8'hAE : 8'hAF, 1'b0, 1'b0);
    check_state("R8 argument not decoded");
    void'(model_cmd(8'h81)); send(1'b0, 8'h81, 1'b0, 1'b0);
    void'(model_cmd(8'h33)); send(1'b0, 8'h33, 1'b0, 1'b0);
    chk("R8 contrast 0x33", contrast, 8'h33);
    void'(model_cmd(8'h33)); send(1'b0, 8'h33, 1'b0, 1'b0);
    check_state("R8 pending cleared, R9 0x33 ignored");

    // R12 set wins over ack, cursor command does not set dirty
    idle_ack();
    chk("R12 ack", dirty, 0);
    probe("R12 write with ack", 8'h66);
    send(1'b1, 8'h77, 1'b0, 1'b1);
    chk("R12 set wins over ack", dirty, 1);
    m_col++;
    idle_ack();
    chk("R12 ack alone clears", dirty, 0);
    void'(model_cmd(8'hB3)); send(1'b0, 8'hB3, 1'b0, 1'b0);
    chk("R12 cursor command leaves dirty", dirty, 0);

    // Force known non-default state, then pin reset with traffic during busy
    void'(model_cmd(8'hAF)); send(1'b0, 8'hAF, 1'b0, 1'b0);
    void'(model_cmd(8'hA7)); send(1'b0, 8'hA7, 1'b0, 1'b0);
    void'(model_cmd(8'hA1)); send(1'b0, 8'hA1, 1'b0, 1'b0);
    void'(model_cmd(8'hC8)); send(1'b0, 8'hC8, 1'b0, 1'b0);
    void'(model_cmd(8'h81)); send(1'b0, 8'h81, 1'b0, 1'b0);
    disp_rst_n = 1'b0;
    @(negedge clk);
    model_reset();
    chk("R10 pin reset busy", busy, 1);
    chk("R10 pin reset dirty", dirty, 0);
    check_state("R10 pin reset");
    disp_rst_n = 1'b1;
    byte_valid = 1'b1; cs_n = 1'b0; dc = 1'b0; byte_in = 8'hAF;
    @(negedge clk);
    check_sweep();
    cs_n = 1'b1;
    check_state("R11 bytes dropped while busy");
    probe("R10 origin after pin reset", 8'h99);
    void'(model_cmd(8'h44)); send(1'b0, 8'h44, 1'b0, 1'b0);
    check_state("R10 pending cleared by reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule